// File: doc/BRIEF.md
# Host Interrupt Mask and Acknowledge Unit

This block gathers the event flags of a command/data host port and turns them into one active-high interrupt line for the local microcontroller. Six sticky status bits are kept: command received, transfer end, data request, ultra-DMA stop, soft reset and a CRC/compare error flag. Each bit is set by a one-cycle pulse from the surrounding transfer logic. The microcontroller reads the bits through a status register.

A byte-wide enable register masks each interrupt source. The masks act only on the interrupt line and never alter a status bit, so a source that is pending while masked raises the line as soon as it is unmasked again. The soft-reset enable has the opposite polarity to the other enables. It leaves reset set, which keeps that source off the line until firmware clears the bit. A write of any value to a separate acknowledge address clears the transfer-end bit and the error flag.

The interrupt line is driven by a two-state machine, `PIN_IDLE` and `PIN_ACTIVE`. Transition RAISE goes from `PIN_IDLE` to `PIN_ACTIVE` when any unmasked status bit is set. Transition DROP goes from `PIN_ACTIVE` to `PIN_IDLE` when none is set. Otherwise the machine stays in its current state. The registers sit on a simple bus with address, write data, write strobe, read strobe and read data. Reads are combinational.

Top module: `hic_irq_unit`

## Requirements
- R1: After reset the enable register reads 0x04, the status register reads 0x00 and `irq` is 0.
- R2: A write to address `CTRL_ADDR` (default 0xFF81) loads the enable register at the next clock edge. Bit 7 enables command, bit 6 transfer end, bit 5 data request and bit 4 ultra-DMA stop, and for these four bits 1 means enabled. Without a write the register holds its value.
- R3: Writing the enable register never sets or clears any status bit.
- R4: A status bit that is pending while its enable is 0 stays set. It drives `irq` high again once the enable is written back to 1.
- R5: Enable bit 2 has inverted polarity: 0 lets a set soft-reset status bit drive `irq`, and 1 blocks it.
- R6: A write to `ACK_ADDR` (default 0xFF85) clears status bit 6 (transfer end) and bit 0 (CRC/compare error) whatever the data value. All other status bits are unchanged.
- R7: An event pulse and an acknowledge in the same cycle leave the status bit set.
- R8: An event pulse present before clock edge k makes its status bit readable after edge k. `irq` then equals the OR over sources of (status AND effective enable) registered once, so it changes after edge k+1. The error flag (status bit 0) never drives `irq`.
- R9: Enable bits 3, 1 and 0 ignore writes and always read 0.
- R10: The status register at `STAT_ADDR` (default 0xFF84) has this layout: bit 7 command, bit 6 transfer end, bit 5 data request, bit 4 ultra-DMA stop, bit 2 soft reset, bit 0 CRC/compare error. Bits 3 and 1 read 0. `rd_data` is 0 when `rd_en` is low or when the address is not mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Register address |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, combinational |
| ev_cmd | input | 1 | Command-received event pulse |
| ev_dte | input | 1 | Transfer-end event pulse |
| ev_drq | input | 1 | Data-request event pulse |
| ev_ustop | input | 1 | Ultra-DMA stop event pulse |
| ev_srst | input | 1 | Soft-reset event pulse |
| ev_crcerr | input | 1 | CRC/compare error event pulse |
| irq | output | 1 | Active-high interrupt to the microcontroller |

## Verification
On every cycle the embedded assertions check four things: the status bits hold when no pulse or acknowledge is present, a pulse always wins over a same-cycle clear, the interrupt line follows the registered masked OR, and the soft-reset polarity holds. They also check that the unused enable bits always read zero. The bench's scenarios are needed for the rest. These are the full cross of every pending-source pattern with every mask setting, the exact readback of every enable value, and the disable-then-re-enable sequence. They also cover the claim that acknowledge data is ignored and the cycle in which `irq` first rises.

// File: rtl/hic_pkg.sv
package hic_pkg;
    localparam int unsigned REG_W     = 8;
    localparam int unsigned BIT_CMD   = 7;
    localparam int unsigned BIT_DTE   = 6;
    localparam int unsigned BIT_DRQ   = 5;
    localparam int unsigned BIT_USTOP = 4;
    localparam int unsigned BIT_SRST  = 2;
    localparam int unsigned BIT_CRC   = 0;

    localparam logic [REG_W-1:0] CTRL_KEEP  = 8'hF4;
    localparam logic [REG_W-1:0] CTRL_RESET = 8'h04;
    localparam logic [REG_W-1:0] STAT_MAP   = 8'hF5;
    localparam logic [REG_W-1:0] ACK_MASK   = (8'h01 << BIT_DTE) | (8'h01 << BIT_CRC);

    typedef enum logic [0:0] {
        PIN_IDLE   = 1'b0,
        PIN_ACTIVE = 1'b1
    } pin_state_t;
endpackage

// File: rtl/hic_mask_reg.sv
module hic_mask_reg
    import hic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] load_data,
    output logic [REG_W-1:0] ctrl,
    output logic [REG_W-1:0] en_eff
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl <= CTRL_RESET;
        else if (load)
            ctrl <= load_data & CTRL_KEEP;
    end

    always_comb begin
        en_eff            = '0;
        en_eff[BIT_CMD]   = ctrl[BIT_CMD];
        en_eff[BIT_DTE]   = ctrl[BIT_DTE];
        en_eff[BIT_DRQ]   = ctrl[BIT_DRQ];
        en_eff[BIT_USTOP] = ctrl[BIT_USTOP];
        en_eff[BIT_SRST]  = ~ctrl[BIT_SRST];
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ctrl)); // R2
endmodule

// File: rtl/hic_status_bank.sv
module hic_status_bank
    import hic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_vec,
    input  logic             ack,
    output logic [REG_W-1:0] status
);
    logic [REG_W-1:0] clr_vec;

    assign clr_vec = ack ? ACK_MASK : '0;

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (STAT_MAP[i]) begin : g_used
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    status[i] <= 1'b0;
                else if (set_vec[i])
                    status[i] <= 1'b1;
                else if (clr_vec[i])
                    status[i] <= 1'b0;
            end
        end else begin : g_unused
            assign status[i] = 1'b0;
        end
    end

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0 && !ack) |=> $stable(status)); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(set_vec) & STAT_MAP & ~status) == '0)); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> ((status & ACK_MASK & ~$past(set_vec)) == '0)); // R6
endmodule

// File: rtl/hic_irq_fsm.sv
module hic_irq_fsm
    import hic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic irq
);
    pin_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= PIN_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PIN_IDLE:   if (req)  state_nx = PIN_ACTIVE;  // RAISE
            PIN_ACTIVE: if (!req) state_nx = PIN_IDLE;    // DROP
            default:    state_nx = PIN_IDLE;
        endcase
    end

    always_comb begin
        irq = (state == PIN_ACTIVE);
    end
endmodule

// File: rtl/hic_irq_unit.sv
module hic_irq_unit
    import hic_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]    CTRL_ADDR = 16'hFF81,
    parameter logic [ADDR_W-1:0]    STAT_ADDR = 16'hFF84,
    parameter logic [ADDR_W-1:0]    ACK_ADDR  = 16'hFF85
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rd_data,
    input  logic              ev_cmd,
    input  logic              ev_dte,
    input  logic              ev_drq,
    input  logic              ev_ustop,
    input  logic              ev_srst,
    input  logic              ev_crcerr,
    output logic              irq
);
    logic             ctrl_wr;
    logic             ack_wr;
    logic [REG_W-1:0] ctrl;
    logic [REG_W-1:0] en_eff;
    logic [REG_W-1:0] status;
    logic [REG_W-1:0] set_vec;
    logic             req;

    assign ctrl_wr = wr_en && (bus_addr == CTRL_ADDR);
    assign ack_wr  = wr_en && (bus_addr == ACK_ADDR);

    always_comb begin
        set_vec            = '0;
        set_vec[BIT_CMD]   = ev_cmd;
        set_vec[BIT_DTE]   = ev_dte;
        set_vec[BIT_DRQ]   = ev_drq;
        set_vec[BIT_USTOP] = ev_ustop;
        set_vec[BIT_SRST]  = ev_srst;
        set_vec[BIT_CRC]   = ev_crcerr;
    end

    hic_mask_reg u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ctrl_wr),
        .load_data (wr_data),
        .ctrl      (ctrl),
        .en_eff    (en_eff)
    );

    hic_status_bank u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .ack     (ack_wr),
        .status  (status)
    );

    assign req = |(status & en_eff);

    hic_irq_fsm u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .irq   (irq)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (bus_addr == CTRL_ADDR)
                rd_data = ctrl;
            else if (bus_addr == STAT_ADDR)
                rd_data = status;
        end
    end

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(status & en_eff)))); // R8
    AST_SRST_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BIT_SRST] && !ctrl[BIT_SRST]) |=> irq); // R5
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr == CTRL_ADDR) |-> (rd_data[3] == 1'b0 && rd_data[1:0] == 2'b00)); // R9
endmodule

// File: tb/sim_hic_irq_unit.sv
`timescale 1ns/100ps
module sim_hic_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [5:0]  ev = '0;   // {cmd, dte, drq, ustop, srst, crcerr}
    logic        irq;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    localparam logic [15:0] A_CTRL = 16'hFF81;
    localparam logic [15:0] A_STAT = 16'hFF84;
    localparam logic [15:0] A_ACK  = 16'hFF85;

    always #2.5 clk = ~clk;

    hic_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
        .ev_cmd(ev[5]), .ev_dte(ev[4]), .ev_drq(ev[3]), .ev_ustop(ev[2]),
        .ev_srst(ev[1]), .ev_crcerr(ev[0]), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        bus_addr = a; rd_en = 1'b1; #1; d = rd_data; rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] e);
        @(negedge clk); ev = e;
        @(negedge clk); ev = '0;
    endtask

    function automatic logic [7:0] stat_of(input logic [5:0] e);
        return {e[5], e[4], e[3], e[2], 1'b0, e[1], 1'b0, e[0]};
    endfunction

    initial begin
        logic [7:0] rv;
        do_reset();
        bus_read(A_CTRL, rv); chk("R1 ctrl reset", rv, 8'h04);
        bus_read(A_STAT, rv); chk("R1 status reset", rv, 8'h00);
        chk("R1 irq reset", {7'd0, irq}, 8'h00);

        // R2 R9: every enable value
        for (int v = 0; v < 256; v++) begin
            bus_write(A_CTRL, v[7:0]);
            bus_read(A_CTRL, rv);
            chk("R2 R9 ctrl readback", rv, v[7:0] & 8'hF4);
        end
        bus_write(A_STAT, 8'hFF);
        bus_read(A_CTRL, rv); chk("R2 hold on other address", rv, 8'hF4);

        // R3 R5 R8 R10: all pending patterns crossed with all masks
        for (int p = 0; p < 64; p++) begin
            for (int m = 0; m < 32; m++) begin
                logic [7:0] cv;
                logic       exp_irq;
                cv = {m[4], m[3], m[2], m[1], 1'b0, m[0], 2'b00};
                exp_irq = |(p[5:2] & m[4:1]) | (p[1] & ~m[0]);
                do_reset();
                pulse(p[5:0]);
                bus_write(A_CTRL, cv);
                @(negedge clk);
                chk("R5 R8 irq masked OR", {7'd0, irq}, {7'd0, exp_irq});
                bus_read(A_STAT, rv);
                chk("R3 R10 status unchanged by mask", rv, stat_of(p[5:0]));
            end
        end

        // R10: no read strobe / unmapped address
        do_reset(); pulse(6'h3F);
        rv = rd_data; chk("R10 no strobe reads 0", rv, 8'h00);
        bus_read(16'hFF80, rv); chk("R10 unmapped reads 0", rv, 8'h00);

        // R4: disable then re-enable
        do_reset();
        bus_write(A_CTRL, 8'h44);
        pulse(6'b010000);
        @(negedge clk); chk("R4 irq on", {7'd0, irq}, 8'h01);
        bus_write(A_CTRL, 8'h04);
        @(negedge clk); chk("R4 irq masked", {7'd0, irq}, 8'h00);
        bus_read(A_STAT, rv); chk("R4 status kept", rv, 8'h40);
        bus_write(A_CTRL, 8'h44);
        @(negedge clk); chk("R4 irq again", {7'd0, irq}, 8'h01);

        // R6: ack ignores data, clears only bits 6 and 0
        for (int d = 0; d < 256; d += 37) begin
            do_reset();
            pulse(6'h3F);
            bus_write(A_ACK, d[7:0]);
            bus_read(A_STAT, rv); chk("R6 ack clears dte/crc", rv, 8'hB4);
        end

        // R7: set and ack in the same cycle
        do_reset();
        @(negedge clk); ev = 6'b010001; bus_addr = A_ACK; wr_data = 8'h00; wr_en = 1'b1;
        @(negedge clk); ev = '0; wr_en = 1'b0;
        bus_read(A_STAT, rv); chk("R7 set wins", rv, 8'h41);

        // R8: timing of the first rise, error flag never drives irq
        do_reset();
        bus_write(A_CTRL, 8'hF0);
        pulse(6'b000001);
        @(negedge clk); chk("R8 crc no irq", {7'd0, irq}, 8'h00);
        pulse(6'b100000);
        bus_read(A_STAT, rv); chk("R8 status after edge k", rv, 8'h81);
        chk("R8 irq still low after edge k", {7'd0, irq}, 8'h00);
        @(negedge clk); chk("R8 irq high after edge k+1", {7'd0, irq}, 8'h01);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule